// File: doc/BRIEF.md
# Paired-Instruction Fetch Unit

This block is the front end of a word-addressed accumulator machine. Every 40-bit memory word carries two 20-bit instructions. The unit reads one word at a time and hands the left instruction to the execute stage. It keeps the right instruction in a holding buffer, so that instruction goes out on the next transfer with no second memory access. Each instruction is an 8-bit opcode and a 12-bit operand address. Both fields are offered to the execute stage under a valid/ready handshake.

The pair counter points at the next word, not at the next instruction. It advances once for each word the unit keeps. A jump from the execute stage gives a 12-bit word target and a half-select bit. When the right half is selected, the unit reads that word and sends out only its right instruction. A jump discards any instruction on offer, empties the holding buffer and drops any read still in flight.

The valid words are 0 to 999. If the counter reaches a word beyond that range, the unit raises a sticky fault flag and stops all activity until reset.

Top module: `pair_fetch_unit`

## Requirements
- R1: After synchronous active-high reset, the pair counter is 0, the holding buffer is empty, iss_valid and fault are low, and in the first cycle out of reset the unit requests word 0 (mem_rd high, mem_addr 0).
- R2: In a fetched word, bits 39:20 hold the left instruction and bits 19:0 hold the right one. In each half, the upper 8 bits are the opcode (iss_opcode) and the lower 12 bits are the operand (iss_operand). The left instruction is issued before the right one.
- R3: Without jumps, the unit makes exactly one memory read per word, at consecutive addresses starting from the counter. The right instruction is served from the buffer with no memory read.
- R4: A transfer happens on a clock edge where iss_valid and iss_ready are both high and jmp_valid is low. While iss_valid is high and the transfer is held off, iss_valid stays high and the opcode and operand stay unchanged.
- R5: A jump with jmp_right low makes the next transfers the left and then the right instruction of word jmp_target, followed by word jmp_target+1.
- R6: A jump with jmp_right high reads word jmp_target and issues only its right instruction. Fetch then continues with the left instruction of jmp_target+1.
- R7: A jump takes priority over a transfer in the same cycle. It squashes the offered instruction and the buffered right instruction. A word still being read when the jump arrives is discarded.
- R8: If the word to fetch is above 999, fault goes high and no read is made. fault then stays high, iss_valid and mem_rd stay low, and jumps are ignored until reset.
- R9: mem_rd is high for one cycle per request. No new request is made until the word for the previous one has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Word address of the read request |
| mem_rd | output | 1 | Read request strobe, one cycle |
| mem_rdata | input | 40 | Returned memory word |
| mem_rvalid | input | 1 | mem_rdata is valid this cycle |
| iss_valid | output | 1 | An instruction is on offer |
| iss_ready | input | 1 | Execute stage accepts the offered instruction |
| iss_opcode | output | 8 | Opcode of the offered instruction |
| iss_operand | output | 12 | Operand address of the offered instruction |
| jmp_valid | input | 1 | Taken jump this cycle |
| jmp_target | input | 12 | Word address of the jump target |
| jmp_right | input | 1 | Jump enters at the right half of the target word |
| fault | output | 1 | Sticky fetch-range fault |

## Verification
Memory words are filled from an address-derived formula that gives each half, opcode and operand a distinct value. This way, swapping halves or fields, or serving a stale buffer entry, shows up in the transferred data. A straight run with ready held high and zero read latency checks the read count and read addresses against the number of instructions consumed. A run with ready randomly withheld separates a design that keeps its offer stable from one that moves on early. Directed jumps cover:
- both halves,
- a read still in flight,
- a buffered right instruction,
- the edge of the address range (word 999) and a target far beyond it.

A long random phase with random read latency and random jumps is compared against a sequential model of counter and half.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

    localparam int WORD_W = 40;
    localparam int HALF_W = WORD_W / 2;
    localparam int OP_W   = 8;
    localparam int ADR_W  = HALF_W - OP_W;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [ADR_W-1:0] adr;
    } instr_t;

    typedef enum logic [1:0] {
        ST_REQ   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_HALT  = 2'd3
    } fstate_t;

    // Select one half of a fetched word; left half sits in the upper bits.
    function automatic instr_t pick_half(input logic [WORD_W-1:0] w, input logic right);
        logic [HALF_W-1:0] h;
        h = right ? w[HALF_W-1:0] : w[WORD_W-1:HALF_W];
        return instr_t'(h);
    endfunction

endpackage

// File: rtl/pfu_pc.sv
module pfu_pc #(
    parameter int ADR_W     = 12,
    parameter int LAST_WORD = 999
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ADR_W-1:0] load_val,
    input  logic             step,
    output logic [ADR_W-1:0] pc,
    output logic             beyond
);
    localparam logic [ADR_W-1:0] LAST_A = ADR_W'(LAST_WORD);

    always_ff @(posedge clk) begin
        if (rst)       pc <= '0;
        else if (load) pc <= load_val;
        else if (step) pc <= pc + 1'b1;
    end

    assign beyond = (pc > LAST_A);

    // R3: a kept word advances the pair counter by exactly one
    p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (pc == $past(pc) + 1'b1));

    // R5: a jump lands the counter on its target
    p_pc_load_r5: assert property (@(posedge clk) disable iff (rst)
        load |=> (pc == $past(load_val)));
endmodule

// File: rtl/pfu_hold.sv
module pfu_hold
    import pfu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   clear,
    input  logic   take,
    input  instr_t din,
    output logic   full,
    output instr_t dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            dout <= '0;
        end else if (clear) begin
            full <= 1'b0;
        end else if (load) begin
            full <= 1'b1;
            dout <= din;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R3: the buffer is only refilled once its previous entry is gone
    p_hold_no_overwrite_r3: assert property (@(posedge clk) disable iff (rst)
        (load && !clear) |-> !full);

    // R7: a clear leaves the buffer empty
    p_hold_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clear |=> !full);
endmodule

// File: rtl/pfu_issue.sv
module pfu_issue
    import pfu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   fire,
    input  logic   kill,
    input  instr_t din,
    output logic   valid,
    output instr_t dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (kill) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (fire) begin
            valid <= 1'b0;
        end
    end

    // R4: an offer not taken, killed or replaced stays put
    p_offer_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && !fire && !kill && !load) |=> (valid && $stable(dout)));
endmodule

// File: rtl/pair_fetch_unit.sv
module pair_fetch_unit
    import pfu_pkg::*;
#(
    parameter int LAST_WORD = 999
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADR_W-1:0]  mem_addr,
    output logic              mem_rd,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [OP_W-1:0]   iss_opcode,
    output logic [ADR_W-1:0]  iss_operand,
    input  logic              jmp_valid,
    input  logic [ADR_W-1:0]  jmp_target,
    input  logic              jmp_right,
    output logic              fault
);
    localparam logic [ADR_W-1:0] LAST_A = ADR_W'(LAST_WORD);

    fstate_t          state_q, state_d;
    logic             drop_q;
    logic             skip_q;
    logic [ADR_W-1:0] pc;
    logic             pc_beyond;
    logic             jmp_take, fire, word_in, keep;
    logic             hold_full, hold_load, hold_take;
    instr_t           hold_dout, hold_din;
    logic             iss_load;
    instr_t           iss_din, iss_dout;

    assign jmp_take = jmp_valid && (state_q != ST_HALT);
    assign fire     = iss_valid && iss_ready && !jmp_valid;
    assign word_in  = (state_q == ST_WAIT) && mem_rvalid;
    assign keep     = word_in && !drop_q && !jmp_valid;

    assign mem_rd   = (state_q == ST_REQ) && !jmp_valid && !pc_beyond;
    assign mem_addr = pc;
    assign fault    = (state_q == ST_HALT);

    assign hold_din  = pick_half(mem_rdata, 1'b1);
    assign hold_load = keep && !skip_q;
    assign hold_take = fire && hold_full;

    assign iss_load = keep || hold_take;
    assign iss_din  = keep ? pick_half(mem_rdata, skip_q) : hold_dout;

    assign iss_opcode  = iss_dout.op;
    assign iss_operand = iss_dout.adr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REQ: begin
                if (jmp_valid)      state_d = ST_REQ;
                else if (pc_beyond) state_d = ST_HALT;
                else                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (word_in)        state_d = keep ? ST_ISSUE : ST_REQ;
            end
            ST_ISSUE: begin
                if (jmp_valid)                  state_d = ST_REQ;
                else if (fire && !hold_full)    state_d = ST_REQ;
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_REQ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_REQ;
            drop_q  <= 1'b0;
            skip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (word_in)
                drop_q <= 1'b0;
            else if (jmp_take && state_q == ST_WAIT)
                drop_q <= 1'b1;
            if (jmp_take)
                skip_q <= jmp_right;
            else if (keep)
                skip_q <= 1'b0;
        end
    end

    pfu_pc #(.ADR_W(ADR_W), .LAST_WORD(LAST_WORD)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .load     (jmp_take),
        .load_val (jmp_target),
        .step     (keep),
        .pc       (pc),
        .beyond   (pc_beyond)
    );

    pfu_hold u_hold (
        .clk   (clk),
        .rst   (rst),
        .load  (hold_load),
        .clear (jmp_take),
        .take  (hold_take),
        .din   (hold_din),
        .full  (hold_full),
        .dout  (hold_dout)
    );

    pfu_issue u_issue (
        .clk   (clk),
        .rst   (rst),
        .load  (iss_load),
        .fire  (fire),
        .kill  (jmp_take),
        .din   (iss_din),
        .valid (iss_valid),
        .dout  (iss_dout)
    );

    // R8: no read ever leaves for a word beyond the range
    p_rd_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr <= LAST_A));

    // R8: the fault is sticky
    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    // R8: a faulted unit neither offers nor reads
    p_fault_silent_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!iss_valid && !mem_rd));

    // R9: a request strobe lasts one cycle
    p_rd_single_r9: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R4: a stalled offer stays valid and unchanged
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready && !jmp_valid) |=>
            (iss_valid && $stable(iss_opcode) && $stable(iss_operand)));

    // R7: a jump squashes the offered instruction
    p_jump_squash_r7: assert property (@(posedge clk) disable iff (rst)
        (jmp_valid && !fault) |=> !iss_valid);
endmodule

// File: tb/pair_fetch_unit_test.sv
module pair_fetch_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic        mem_rd;
    logic [39:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic [7:0]  iss_opcode;
    logic [11:0] iss_operand;
    logic        jmp_valid = 1'b0;
    logic [11:0] jmp_target = '0;
    logic        jmp_right = 1'b0;
    logic        fault;

    always #5 clk = ~clk;

    pair_fetch_unit uut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .iss_valid(iss_valid),
        .iss_ready(iss_ready), .iss_opcode(iss_opcode), .iss_operand(iss_operand),
        .jmp_valid(jmp_valid), .jmp_target(jmp_target), .jmp_right(jmp_right),
        .fault(fault)
    );

    int    n_chk = 0;
    int    n_err = 0;
    int    n_acc = 0;
    int    lat_mode = 0;
    int    rd_count = 0;
    bit    bad_rd = 0;
    bit    r9_bad = 0;
    bit    prev_rd = 0;
    logic [11:0] addr_log [16];
    logic [19:0] acc_log [8];
    int    acc_idx = 0;
    string cur_tag = "R2";
    int    m_pc = 0;
    bit    m_half = 0;
    bit    st_v = 0;
    logic [19:0] st_val = '0;

    function automatic logic [39:0] word_of(input int a);
        logic [7:0]  ol, orr;
        logic [11:0] al, ar;
        ol  = 8'(a * 7 + 3);
        al  = 12'(a * 5 + 1);
        orr = 8'(a * 11 + 90);
        ar  = 12'(4095 - a);
        return {ol, al, orr, ar};
    endfunction

    function automatic logic [19:0] exp_instr(input int a, input bit right);
        logic [39:0] w;
        w = word_of(a);
        return right ? w[19:0] : w[39:20];
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // memory model with selectable latency
    logic        m_busy = 0;
    int          m_cnt = 0;
    logic [11:0] m_addr = '0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst) begin
            m_busy <= 1'b0;
        end else if (m_busy) begin
            if (m_cnt == 0) begin
                m_busy     <= 1'b0;
                mem_rvalid <= 1'b1;
                mem_rdata  <= word_of(int'(m_addr));
            end else begin
                m_cnt <= m_cnt - 1;
            end
        end else if (mem_rd) begin
            m_busy <= 1'b1;
            m_addr <= mem_addr;
            m_cnt  <= (lat_mode == 3) ? int'($urandom % 3) : lat_mode;
        end
    end

    // read monitor
    always @(posedge clk) begin
        if (!rst) begin
            if (mem_rd) begin
                if (rd_count < 16) addr_log[rd_count] = mem_addr;
                rd_count++;
                if (mem_addr > 12'd999) bad_rd = 1;
                if (m_busy || prev_rd) r9_bad = 1;
            end
            prev_rd = mem_rd;
        end else begin
            prev_rd = 0;
        end
    end

    // one cycle: drive inputs at the falling edge, check against the model
    task automatic cyc(input bit r, input bit j, input int t, input bit h);
        iss_ready  = r;
        jmp_valid  = j;
        jmp_target = 12'(t);
        jmp_right  = h;
        if (st_v)
            chk(iss_valid && ({iss_opcode, iss_operand} == st_val), "R4",
                "stalled offer changed", {19'd0, iss_valid, iss_opcode, iss_operand}, {20'd1, st_val});
        st_v   = iss_valid && !r && !j;
        st_val = {iss_opcode, iss_operand};
        if (iss_valid && m_pc > 999)
            chk(0, "R8", "offer past range", {28'd0, 12'(m_pc)}, 40'd999);
        if (iss_valid && r && !j) begin
            chk({iss_opcode, iss_operand} == exp_instr(m_pc, m_half), cur_tag,
                "transferred instruction", {20'd0, iss_opcode, iss_operand},
                {20'd0, exp_instr(m_pc, m_half)});
            if (acc_idx < 8) acc_log[acc_idx] = {iss_opcode, iss_operand};
            acc_idx++;
            n_acc++;
            if (m_half) begin m_pc++; m_half = 0; end
            else m_half = 1;
        end
        if (j && !fault) begin
            m_pc   = t;
            m_half = h;
        end
        @(negedge clk);
    endtask

    task automatic run_acc(input int n, input bit rnd);
        int goal;
        int guard;
        goal  = n_acc + n;
        guard = 0;
        while (n_acc < goal && guard < 3000) begin
            cyc(rnd ? bit'($urandom % 3 != 0) : 1'b1, 1'b0, 0, 1'b0);
            guard++;
        end
        chk(n_acc >= goal, cur_tag, "accept count", 40'(n_acc), 40'(goal));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        iss_ready = 1'b0;
        jmp_valid = 1'b0;
        repeat (3) @(negedge clk);
        m_pc = 0; m_half = 0; st_v = 0; acc_idx = 0; rd_count = 0;
        rst = 1'b0;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int since_jmp;
        void'($urandom(32'd4242));
        @(negedge clk);

        // R1: reset state
        lat_mode = 0;
        do_reset();
        chk(!iss_valid, "R1", "iss_valid after reset", 40'(iss_valid), 40'd0);
        chk(!fault, "R1", "fault after reset", 40'(fault), 40'd0);
        chk(mem_rd && mem_addr == 12'd0, "R1", "first request", {27'd0, mem_rd, mem_addr}, {27'd0, 1'b1, 12'd0});
        @(negedge clk);

        // R2 / R3: straight run, zero latency
        cur_tag = "R2";
        run_acc(8, 0);
        chk(acc_log[0] == word_of(0)[39:20], "R2", "left half first", 40'(acc_log[0]), 40'(word_of(0)[39:20]));
        chk(acc_log[1] == word_of(0)[19:0], "R2", "right half second", 40'(acc_log[1]), 40'(word_of(0)[19:0]));
        chk(rd_count == 4, "R3", "reads per 8 instructions", 40'(rd_count), 40'd4);
        for (int i = 0; i < 4; i++)
            chk(addr_log[i] == 12'(i), "R3", "read address", 40'(addr_log[i]), 40'(i));

        // R4: random back-pressure
        cur_tag = "R4";
        lat_mode = 1;
        run_acc(40, 1);

        // R5: jump to a left half
        cur_tag = "R5";
        cyc(1'b1, 1'b1, 100, 1'b0);
        acc_idx = 0;
        run_acc(3, 0);
        chk(acc_log[0] == exp_instr(100, 0), "R5", "left of target", 40'(acc_log[0]), 40'(exp_instr(100, 0)));
        chk(acc_log[1] == exp_instr(100, 1), "R5", "right of target", 40'(acc_log[1]), 40'(exp_instr(100, 1)));
        chk(acc_log[2] == exp_instr(101, 0), "R5", "next word", 40'(acc_log[2]), 40'(exp_instr(101, 0)));

        // R6: jump to a right half
        cur_tag = "R6";
        lat_mode = 0;
        do_reset();
        cyc(1'b1, 1'b1, 200, 1'b1);
        rd_count = 0;
        acc_idx = 0;
        run_acc(2, 0);
        chk(acc_log[0] == exp_instr(200, 1), "R6", "right only", 40'(acc_log[0]), 40'(exp_instr(200, 1)));
        chk(acc_log[1] == exp_instr(201, 0), "R6", "then next left", 40'(acc_log[1]), 40'(exp_instr(201, 0)));
        chk(rd_count == 2, "R6", "reads for right entry", 40'(rd_count), 40'd2);

        // R7: jump during a pending read, then over a buffered right half
        cur_tag = "R7";
        lat_mode = 2;
        do_reset();
        cyc(1'b1, 1'b0, 0, 1'b0);
        cyc(1'b1, 1'b1, 300, 1'b0);
        acc_idx = 0;
        run_acc(1, 0);
        chk(acc_log[0] == exp_instr(300, 0), "R7", "pending word dropped", 40'(acc_log[0]), 40'(exp_instr(300, 0)));
        chk(iss_valid, "R7", "right half on offer", 40'(iss_valid), 40'd1);
        cyc(1'b1, 1'b1, 400, 1'b1);
        chk(!iss_valid, "R7", "offer squashed", 40'(iss_valid), 40'd0);
        acc_idx = 0;
        run_acc(1, 0);
        chk(acc_log[0] == exp_instr(400, 1), "R7", "buffer squashed", 40'(acc_log[0]), 40'(exp_instr(400, 1)));

        // R8: running off the end of memory
        cur_tag = "R8";
        lat_mode = 0;
        do_reset();
        cyc(1'b1, 1'b1, 998, 1'b0);
        run_acc(4, 0);
        repeat (10) cyc(1'b1, 1'b0, 0, 1'b0);
        chk(fault, "R8", "fault raised", 40'(fault), 40'd1);
        chk(!iss_valid, "R8", "no offer after fault", 40'(iss_valid), 40'd0);
        chk(!bad_rd, "R8", "no read beyond range", 40'(bad_rd), 40'd0);
        begin
            int rc;
            rc = rd_count;
            cyc(1'b1, 1'b1, 5, 1'b0);
            repeat (10) cyc(1'b1, 1'b0, 0, 1'b0);
            chk(fault && !iss_valid, "R8", "jump ignored after fault", {38'd0, fault, iss_valid}, 40'd2);
            chk(rd_count == rc, "R8", "no reads after fault", 40'(rd_count), 40'(rc));
        end
        do_reset();
        cyc(1'b1, 1'b1, 1005, 1'b1);
        begin
            int a0;
            a0 = n_acc;
            repeat (5) cyc(1'b1, 1'b0, 0, 1'b0);
            chk(fault && n_acc == a0, "R8", "far target faults", {39'd0, fault}, 40'd1);
        end

        // Random phase: R2, R3, R5, R6, R7 against the model
        cur_tag = "R3";
        lat_mode = 3;
        do_reset();
        since_jmp = 0;
        for (int k = 0; k < 4000; k++) begin
            bit j;
            j = ($urandom % 40 == 0) || (since_jmp > 150);
            if (j) since_jmp = 0; else since_jmp++;
            cyc(bit'($urandom % 4 != 0), j, int'($urandom % 700), bit'($urandom % 2));
        end
        chk(!fault, "R8", "no fault in range", 40'(fault), 40'd0);

        chk(!r9_bad, "R9", "request overlap", 40'(r9_bad), 40'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule